// File: doc/BRIEF.md
# Transfer Length Counter with Identity Readback

This block holds the 24-bit byte count that a storage bus controller programs before moving data. Software writes three byte registers (low, mid, high) into a shadow copy. The copy that software reads back and that the length logic uses is a separate, readable copy. That readable copy changes only when a command arrives with its DMA bit set. The same command write also sets or clears the block's DMA mode flag.

When the controller asks to start a transfer, the block works out the effective length and presents it one cycle later. The effective length is the smaller of the programmed count and either the size of the remaining phase or the command buffer size. A programmed count of zero stands for 65536 bytes. Until the high byte is first written after reset, reading the high byte returns a fixed identity code, so a driver can probe which controller it has. Any write to a count byte, and any transfer start made in DMA mode, sends a one-cycle strobe to the status logic so that it clears its transfer-complete bit.

Top module: `xfer_counter`

## Requirements
- R1: After reset, all readable count bytes read 0, the high byte reads as ID_CODE, dma_mode is 0, and eff_valid and clr_tc are 0.
- R2: A write (wr_en with wr_sel 0 = low, 1 = mid, 2 = high) updates only the shadow copy. The value read back at that index does not change until a command write with the DMA bit set.
- R3: A command write with cmd_dma=1 copies all three shadow bytes (their values before any byte write in the same cycle) into the readable bytes and sets dma_mode on the next cycle. A command write with cmd_dma=0 clears dma_mode and leaves the readable bytes unchanged.
- R4: A read of the high byte (rd_sel 2) returns ID_CODE until a write to wr_sel 2 has been registered. After that it returns the readable high byte until the next reset.
- R5: A write to wr_sel 0, 1 or 2 pulses clr_tc for exactly one cycle on the cycle after the write. A write with wr_sel 3 has no effect on any output.
- R6: A one-cycle xfer_start raises eff_valid for exactly the next cycle. With cmd_collect=0, eff_len = min(C, |remain|), where C = low | mid<<8 | high<<16 of the readable bytes and remain is a signed 17-bit phase count.
- R7: A programmed count of zero is used as 65536. With cmd_collect=1, eff_len = min(C, CMDBUF_LEN) and remain is ignored.
- R8: An xfer_start while dma_mode is 1 pulses clr_tc on the next cycle. An xfer_start while dma_mode is 0 does not.
- R9: A read with rd_sel 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| wr_en | input | 1 | Count byte write strobe |
| wr_sel | input | 2 | Byte index for a write (0 low, 1 mid, 2 high) |
| wr_data | input | 8 | Write data |
| cmd_wr | input | 1 | Command write strobe |
| cmd_dma | input | 1 | DMA bit of the command being written |
| rd_sel | input | 2 | Byte index for a read |
| rd_data | output | 8 | Read data for rd_sel |
| xfer_start | input | 1 | Transfer start request, one cycle |
| cmd_collect | input | 1 | Command-collect mode: bound the length by the command buffer |
| remain | input | 17 | Signed remaining phase byte count |
| eff_len | output | 17 | Effective transfer length |
| eff_valid | output | 1 | eff_len is valid this cycle |
| dma_mode | output | 1 | DMA mode flag |
| clr_tc | output | 1 | One-cycle request to clear transfer-complete status |

## Verification
Some outcomes depend on events that coincide in one cycle, and these are the hardest to reach. One case is a transfer start in the same cycle as a DMA command: the start must still use the old readable count. Another is a byte write in the same cycle as a DMA command: the old shadow byte must be copied. A third is the extreme remaining count of -65536 against a zeroed counter. A long run of random cycles drives writes, commands, starts and reads with independent probabilities, and biases remain toward 0, ±1 and the extremes so these cases occur. A reference model steps through every cycle and checks every output after each edge. A directed reset in the middle of the run shows that the high-byte identity readback returns.

// File: rtl/xc_pkg.sv
package xc_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = 3;
    localparam int SEL_W     = 2;
    localparam int CNT_W     = BYTE_W * NUM_BYTES;
    localparam int LEN_W     = 17;
    localparam int REM_W     = 17;
    localparam int HI_IDX    = NUM_BYTES - 1;

    typedef logic [NUM_BYTES-1:0][BYTE_W-1:0] cnt_bytes_t;

    typedef struct packed {
        cnt_bytes_t shadow;
        cnt_bytes_t visible;
        logic       hi_seen;
        logic       dma_on;
    } regs_state_t;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             valid;
    } len_state_t;
endpackage

// File: rtl/xc_regfile.sv
module xc_regfile
    import xc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ID_CODE = 8'hA2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              cmd_wr,
    input  logic              cmd_dma,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output logic [CNT_W-1:0]  cnt_value,
    output logic              dma_mode,
    output logic              byte_wr_hit
);
    regs_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cmd_wr) begin
            s_d.dma_on = cmd_dma;
            if (cmd_dma) begin
                s_d.visible = s_q.shadow;
            end
        end
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (wr_en && (wr_sel == SEL_W'(i))) begin
                s_d.shadow[i] = wr_data;
            end
        end
        if (wr_en && (wr_sel == SEL_W'(HI_IDX))) begin
            s_d.hi_seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    logic [NUM_BYTES-1:0][BYTE_W-1:0] rd_view;
    genvar g;
    generate
        for (g = 0; g < NUM_BYTES; g++) begin : g_view
            if (g == HI_IDX) begin : g_hi
                assign rd_view[g] = s_q.hi_seen ? s_q.visible[g] : ID_CODE;
            end else begin : g_lo
                assign rd_view[g] = s_q.visible[g];
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                rd_data = rd_view[i];
            end
        end
    end

    assign cnt_value   = s_q.visible;
    assign dma_mode    = s_q.dma_on;
    assign byte_wr_hit = wr_en && (wr_sel < SEL_W'(NUM_BYTES));

    // R4: once the high byte is written, the flag holds until reset
    assert_hi_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.hi_seen |=> s_q.hi_seen);
    // R3: the DMA flag follows the command bit
    assert_dma_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (dma_mode == $past(cmd_dma)));
    // R2: with no command, the readable copy holds
    assert_visible_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(cnt_value));
endmodule

// File: rtl/xc_len.sv
module xc_len
    import xc_pkg::*;
#(
    parameter int CMDBUF_LEN = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    collect,
    input  logic [CNT_W-1:0]        cnt_value,
    input  logic signed [REM_W-1:0] remain,
    output logic [LEN_W-1:0]        eff_len,
    output logic                    eff_valid
);
    localparam int CMP_W = CNT_W + 1;
    localparam logic [CMP_W-1:0] ZERO_AS = CMP_W'(1) << 16;
    localparam logic [CMP_W-1:0] BUF_LIM = CMP_W'(CMDBUF_LEN);

    len_state_t s_d, s_q;

    logic [REM_W-1:0] rem_mag;
    logic [CMP_W-1:0] cnt_use;
    logic [CMP_W-1:0] lim;
    logic [CMP_W-1:0] pick;

    always_comb begin
        rem_mag = remain[REM_W-1] ? REM_W'(-remain) : REM_W'(remain);
        cnt_use = (cnt_value == '0) ? ZERO_AS : CMP_W'(cnt_value);
        lim     = collect ? BUF_LIM : CMP_W'(rem_mag);
        pick    = (cnt_use < lim) ? cnt_use : lim;
    end

    always_comb begin
        s_d       = s_q;
        s_d.valid = start;
        if (start) begin
            s_d.len = pick[LEN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign eff_len   = s_q.len;
    assign eff_valid = s_q.valid;

    // R6: one valid cycle per start request, in the following cycle
    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> eff_valid);
    assert_valid_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eff_valid |-> $past(start));
    // R6: the length never exceeds the largest phase magnitude
    assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eff_valid |-> (eff_len <= LEN_W'(65536)));
    // R7: in collect mode the command buffer bounds the length
    assert_collect_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && collect) |=> (eff_len <= LEN_W'(CMDBUF_LEN)));
endmodule

// File: rtl/xc_tc_strobe.sv
module xc_tc_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_wr_hit,
    input  logic start,
    input  logic dma_mode,
    output logic clr_tc
);
    logic pulse_d, pulse_q;

    always_comb begin
        pulse_d = byte_wr_hit || (start && dma_mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= pulse_d;
        end
    end

    assign clr_tc = pulse_q;

    // R5: a counter byte write always requests a status clear
    assert_wr_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_wr_hit |=> clr_tc);
    // R8: a start in DMA mode requests a status clear
    assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dma_mode) |=> clr_tc);
endmodule

// File: rtl/xfer_counter.sv
module xfer_counter
    import xc_pkg::*;
#(
    parameter logic [7:0] ID_CODE    = 8'hA2,
    parameter int         CMDBUF_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [7:0]        wr_data,
    input  logic              cmd_wr,
    input  logic              cmd_dma,
    input  logic [1:0]        rd_sel,
    output logic [7:0]        rd_data,
    input  logic              xfer_start,
    input  logic              cmd_collect,
    input  logic signed [16:0] remain,
    output logic [16:0]       eff_len,
    output logic              eff_valid,
    output logic              dma_mode,
    output logic              clr_tc
);
    logic [CNT_W-1:0] cnt_value;
    logic             byte_wr_hit;

    xc_regfile #(.ID_CODE(ID_CODE)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cmd_wr(cmd_wr), .cmd_dma(cmd_dma),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .cnt_value(cnt_value), .dma_mode(dma_mode),
        .byte_wr_hit(byte_wr_hit)
    );

    xc_len #(.CMDBUF_LEN(CMDBUF_LEN)) u_len (
        .clk(clk), .rst_n(rst_n),
        .start(xfer_start), .collect(cmd_collect),
        .cnt_value(cnt_value), .remain(remain),
        .eff_len(eff_len), .eff_valid(eff_valid)
    );

    xc_tc_strobe u_tc (
        .clk(clk), .rst_n(rst_n),
        .byte_wr_hit(byte_wr_hit), .start(xfer_start),
        .dma_mode(dma_mode), .clr_tc(clr_tc)
    );

    // R5: a write with index 3 has no status side effect
    assert_sel3_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3 && !xfer_start) |=> !clr_tc);
endmodule

// File: tb/sim_xfer_counter.sv
module sim_xfer_counter;
    localparam int ID = 8'hA2;
    localparam int BUF = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, cmd_wr = 1'b0, cmd_dma = 1'b0;
    logic xfer_start = 1'b0, cmd_collect = 1'b0;
    logic [1:0] wr_sel = '0, rd_sel = '0;
    logic [7:0] wr_data = '0;
    logic signed [16:0] remain = '0;
    logic [7:0] rd_data;
    logic [16:0] eff_len;
    logic eff_valid, dma_mode, clr_tc;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    xfer_counter #(.ID_CODE(8'hA2), .CMDBUF_LEN(BUF)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cmd_wr(cmd_wr), .cmd_dma(cmd_dma),
        .rd_sel(rd_sel), .rd_data(rd_data), .xfer_start(xfer_start),
        .cmd_collect(cmd_collect), .remain(remain), .eff_len(eff_len),
        .eff_valid(eff_valid), .dma_mode(dma_mode), .clr_tc(clr_tc)
    );

    // reference model
    int m_sh[3];
    int m_vis[3];
    int m_seen, m_dma, m_len, m_valid, m_tc, m_coll;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin m_sh[i] = 0; m_vis[i] = 0; end
            m_seen = 0; m_dma = 0; m_len = 0; m_valid = 0; m_tc = 0; m_coll = 0;
        end else begin
            int c, lim;
            m_tc = ((wr_en && wr_sel != 2'd3) || (xfer_start && m_dma != 0)) ? 1 : 0;
            m_valid = xfer_start ? 1 : 0;
            if (xfer_start) begin
                c = m_vis[0] + m_vis[1] * 256 + m_vis[2] * 65536;
                if (c == 0) c = 65536;
                if (cmd_collect) lim = BUF;
                else lim = (int'(remain) < 0) ? -int'(remain) : int'(remain);
                m_len = (c < lim) ? c : lim;
                m_coll = cmd_collect ? 1 : 0;
            end
            if (cmd_wr) begin
                m_dma = cmd_dma ? 1 : 0;
                if (cmd_dma) for (int i = 0; i < 3; i++) m_vis[i] = m_sh[i];
            end
            if (wr_en && wr_sel != 2'd3) begin
                m_sh[wr_sel] = int'(wr_data);
                if (wr_sel == 2'd2) m_seen = 1;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int er;
        chk("R3 dma_mode", int'(dma_mode), m_dma);
        chk("R5|R8 clr_tc", int'(clr_tc), m_tc);
        chk("R6 eff_valid", int'(eff_valid), m_valid);
        chk(m_coll != 0 ? "R7 eff_len" : "R6 eff_len", int'(eff_len), m_len);
        if (rd_sel == 2'd3) begin
            chk("R9 rd_data", int'(rd_data), 0);
        end else if (rd_sel == 2'd2 && m_seen == 0) begin
            chk("R4 rd_data", int'(rd_data), ID);
        end else begin
            er = m_vis[rd_sel];
            chk("R2 rd_data", int'(rd_data), er);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        compare_all();
        wr_en = 0; cmd_wr = 0; xfer_start = 0;
    endtask

    task automatic wbyte(int sel, int val);
        wr_en = 1; wr_sel = 2'(sel); wr_data = 8'(val); tick();
    endtask

    task automatic cmd(int dma);
        cmd_wr = 1; cmd_dma = dma[0]; tick();
    endtask

    task automatic start(int coll, int rem);
        xfer_start = 1; cmd_collect = coll[0]; remain = 17'(rem); tick();
    endtask

    task automatic sweep_reads();
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s); #1; compare_all();
        end
    endtask

    initial begin
        #40000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #11;
        // R1: reset state
        chk("R1 dma_mode", int'(dma_mode), 0);
        chk("R1 eff_valid", int'(eff_valid), 0);
        chk("R1 clr_tc", int'(clr_tc), 0);
        rd_sel = 2'd2; #1; chk("R1 high id", int'(rd_data), ID);
        rd_sel = 2'd0; #1; chk("R1 low zero", int'(rd_data), 0);
        rst_n = 1;
        tick();
        // R2, R5: shadow writes, no visible change
        wbyte(0, 8'h34); wbyte(1, 8'h12); sweep_reads();
        chk("R4 id before high write", int'(rd_data), 0);
        rd_sel = 2'd2; #1; chk("R4 id before high write", int'(rd_data), ID);
        wbyte(2, 8'h00); sweep_reads();
        rd_sel = 2'd2; #1; chk("R4 high after write", int'(rd_data), 0);
        wbyte(3, 8'hFF); // R5: index 3 ignored
        chk("R5 sel3 no clr", int'(clr_tc), 0);
        // R3: command without DMA leaves visible copy
        cmd(0); sweep_reads();
        cmd(1); sweep_reads();
        rd_sel = 2'd0; #1; chk("R3 copy low", int'(rd_data), 8'h34);
        // R6, R8: start in DMA mode
        start(0, 100); tick();
        start(0, -17'sd5000);
        start(0, 0);
        // R7: collect mode, count zero
        wbyte(0, 0); wbyte(1, 0); cmd(1);
        start(1, 999);
        start(0, -65536);
        cmd(0);
        start(0, 77); // R8: no clear outside DMA mode
        chk("R8 no clr", int'(clr_tc), 0);
        // corner: start and command together use the old count
        wbyte(0, 3); xfer_start = 1; remain = 17'd50; cmd_wr = 1; cmd_dma = 1; tick();
        // corner: write and command together copy the old shadow
        wr_en = 1; wr_sel = 0; wr_data = 8'h99; cmd_wr = 1; cmd_dma = 1; tick();
        // random traffic
        for (int k = 0; k < 3000; k++) begin
            int r;
            wr_en = ($urandom_range(0, 3) == 0);
            wr_sel = 2'($urandom_range(0, 3));
            wr_data = ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom);
            cmd_wr = ($urandom_range(0, 5) == 0);
            cmd_dma = 1'($urandom);
            rd_sel = 2'($urandom_range(0, 3));
            xfer_start = ($urandom_range(0, 2) == 0);
            cmd_collect = ($urandom_range(0, 3) == 0);
            r = $urandom_range(0, 6);
            case (r)
                0: remain = 17'sd0;
                1: remain = 17'sd1;
                2: remain = -17'sd1;
                3: remain = 17'sd65535;
                4: remain = -17'sd65536;
                default: remain = 17'($urandom);
            endcase
            if (k == 1500) begin
                // R1, R4: reset in the middle brings the identity code back
                @(posedge clk); #1; rst_n = 0; #1;
                rd_sel = 2'd2; #1; chk("R1 high id after reset", int'(rd_data), ID);
                chk("R1 dma after reset", int'(dma_mode), 0);
                @(negedge clk); rst_n = 1;
                wr_en = 0; cmd_wr = 0; xfer_start = 0;
            end
            tick();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule